// File: doc/BRIEF.md
# Five-Pin Bidirectional I/O Port

This block is a five-pin general-purpose I/O port that sits on a small microcontroller's internal register bus. Each pin has a bit in an output latch and a bit in a direction register. The pad logic turns these into an output-enable and an output value for each pin. Software reads the direction register back as it is. It reads the port register as the synchronized pin levels, not as the latch contents.

The four low pins can also serve as analog inputs, under a two-bit configuration input. A pin in analog mode reads back as zero. The top pin is open-drain: it can only pull low. Its synchronized input also leaves the block as a clock tap for a timer.

Writes are a full byte, a single-bit set or a single-bit clear. A bit write first reads the target register's current read value, changes one bit, and writes the result back. On the port register, that read value is the pin levels. So a bit write to one pin loads every other latch bit from what its pin shows at that moment.

Top module: `gpio5_port`

## Requirements
- R1: When reset ends, the direction register reads 0x1F (all pins are inputs), the output latch is 0, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: For pins 3..0, a direction bit of 1 gives `pin_oe`=0. A direction bit of 0 gives `pin_oe`=1 with `pin_out` equal to that pin's latch bit.
- R3: `port_rd[4:0]` shows the `pin_in` levels through a two-flop synchronizer. A change on a pin is visible after the second rising clock edge. The value does not depend on the output latch.
- R4: A byte write (`wr_op`=0) with `wr_sel`=0 loads `wr_data[4:0]` into the output latch and leaves the direction register unchanged. With `wr_sel`=1, it loads `wr_data[4:0]` into the direction register instead.
- R5: Pin 4 is open-drain. `pin_out[4]` is always 0. `pin_oe[4]` is 1 only when direction bit 4 is 0 and latch bit 4 is 0.
- R6: `tmr_clk` follows `pin_in[4]` through the same two-flop synchronizer, two rising edges later.
- R7: `ana_cfg` selects which pins are in analog mode. Code 00 puts pins 3..0 in analog mode. Codes 01 and 10 put only pins 1..0 in analog mode. Code 11 puts none in analog mode. A pin in analog mode reads 0 in `port_rd`.
- R8: Analog mode does not override the direction register. `pin_oe` and `pin_out` for pins 3..0 behave as in R2 whatever the value of `ana_cfg`.
- R9: `port_rd[7:5]` and `dir_rd[7:5]` always read 0.
- R10: A bit-set (`wr_op`=1) or bit-clear (`wr_op`=2) at index `wr_bit` works on the target register's current read value. For `wr_sel`=0 that value is `port_rd[4:0]`, so every other latch bit is loaded from its read pin level (0 for analog pins). For `wr_sel`=1 that value is the direction register. An index of 5 to 7 changes no bit, but the copy still takes place.
- R11: `wr_op`=3 is a no-op. Neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 port latch, 1 direction register |
| wr_op | input | 2 | 0 byte write, 1 bit set, 2 bit clear, 3 no-op |
| wr_bit | input | 3 | Bit index for set/clear |
| wr_data | input | 8 | Byte write data |
| ana_cfg | input | 2 | Analog-mode selection for pins 3..0 |
| pin_in | input | 5 | Raw pin levels |
| port_rd | output | 8 | Port register read value |
| dir_rd | output | 8 | Direction register read value |
| pin_oe | output | 5 | Per-pin output driver enable |
| pin_out | output | 5 | Per-pin driven value |
| tmr_clk | output | 1 | Synchronized pin 4 level for the timer |

## Verification
The hardest case to reach is the read-modify-write hazard. Here a bit write silently overwrites other latch bits with pin levels that differ from what was stored. The stimulus first loads the latch with a pattern that differs from the pins. It then waits out the synchronizer latency and issues a set or clear. Some of these bit writes are made with pins in analog mode, so that latch bits are loaded with zeros. One uses an index above the pin count, so the write is pure copying.

// File: rtl/gpio5_pkg.sv
// Package: shared constants and encodings for the five-pin I/O port.
// Assumes: nothing; pure declarations.
package gpio5_pkg;

    // Write operation encodings on wr_op
    typedef enum logic [1:0] {
        OP_BYTE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } wr_op_e;

    // Analog configuration codes on ana_cfg
    localparam logic [1:0] ANA_ALL  = 2'b00;
    localparam logic [1:0] ANA_NONE = 2'b11;

    // Register select values on wr_sel
    localparam logic SEL_PORT = 1'b0;
    localparam logic SEL_DIR  = 1'b1;

endpackage

// File: rtl/gpio5_sync.sv
// Module: gpio5_sync
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes: each bit is treated on its own (no cross-bit coherence); the
// stages reset to 0 so the read path is defined right after reset.
module gpio5_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];

    // First stage captures the raw pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= din;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

    // Count edges since reset so the latency check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R3 R6
            sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio5_ana_map.sv
// Module: gpio5_ana_map
// Decodes the analog configuration code into a per-pin analog mask.
// Assumes: NANA is even. The lower half of the analog-capable pins is analog
// for every code except "none"; the upper half is analog only for "all".
module gpio5_ana_map
    import gpio5_pkg::*;
#(
    parameter int NANA = 4
) (
    input  logic [1:0]      ana_cfg,
    output logic [NANA-1:0] ana_mask
);

    localparam int HALF = NANA / 2;

    genvar i;
    generate
        for (i = 0; i < NANA; i++) begin : g_bit
            if (i < HALF) begin : g_lo
                // Lower half: analog unless everything is digital
                assign ana_mask[i] = (ana_cfg != ANA_NONE);
            end else begin : g_hi
                // Upper half: analog only when everything is analog
                assign ana_mask[i] = (ana_cfg == ANA_ALL);
            end
        end
    endgenerate

endmodule

// File: rtl/gpio5_regs.sv
// Module: gpio5_regs
// Holds the output latch and the direction register, and applies byte,
// bit-set and bit-clear writes. A bit write modifies the target's read value:
// pin view for the port, the register itself for direction.
// Assumes: pin_view is the already-masked port read value.
module gpio5_regs
    import gpio5_pkg::*;
#(
    parameter int NPIN = 5,
    parameter int DW   = 8,
    localparam int BW  = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [1:0]      wr_op,
    input  logic [BW-1:0]   wr_bit,
    input  logic [DW-1:0]   wr_data,
    input  logic [NPIN-1:0] pin_view,
    output logic [NPIN-1:0] lat_q,
    output logic [NPIN-1:0] dir_q
);

    logic [DW-1:0] base_v;
    logic [DW-1:0] mod_v;
    logic          commit;

    // Build the read value of the target and apply the requested change
    always_comb begin
        base_v = '0;
        if (wr_sel == SEL_DIR) base_v[NPIN-1:0] = dir_q;
        else                   base_v[NPIN-1:0] = pin_view;
        mod_v = base_v;
        case (wr_op_e'(wr_op))
            OP_BYTE: mod_v = wr_data;
            OP_SET:  mod_v[wr_bit] = 1'b1;
            OP_CLR:  mod_v[wr_bit] = 1'b0;
            default: mod_v = base_v;
        endcase
    end

    assign commit = wr_en && (wr_op_e'(wr_op) != OP_NONE);

    // Store the modified value into the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '1;
        end else if (commit) begin
            if (wr_sel == SEL_DIR) dir_q <= mod_v[NPIN-1:0];
            else                   lat_q <= mod_v[NPIN-1:0];
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == {NPIN{1'b1}}) && (lat_q == '0));

    // R4
    port_byte_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PORT && wr_op == 2'd0)
        |=> (dir_q == $past(dir_q)) && (lat_q == $past(wr_data[NPIN-1:0])));

    // R10
    port_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PORT && wr_op == 2'd1 && wr_bit < BW'(NPIN))
        |=> lat_q[$past(wr_bit)]);

    // R10
    port_clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PORT && wr_op == 2'd2 && wr_bit < BW'(NPIN))
        |=> !lat_q[$past(wr_bit)]);

    // R11
    noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd3) |=> $stable(lat_q) && $stable(dir_q));

endmodule

// File: rtl/gpio5_drv.sv
// Module: gpio5_drv
// Per-pin output driver control. Push-pull pins drive the latch value when
// their direction bit is 0. The open-drain pin only ever drives low.
// Assumes: direction bit 1 means high-impedance.
module gpio5_drv #(
    parameter int NPIN   = 5,
    parameter int OD_IDX = 4
) (
    input  logic [NPIN-1:0] lat_q,
    input  logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_out
);

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_pin
            if (i == OD_IDX) begin : g_od
                // Open drain: enable only to pull low
                assign pin_oe[i]  = ~dir_q[i] & ~lat_q[i];
                assign pin_out[i] = 1'b0;
            end else begin : g_pp
                // Push-pull: enable follows direction, value follows latch
                assign pin_oe[i]  = ~dir_q[i];
                assign pin_out[i] = lat_q[i];
            end
        end
    endgenerate

endmodule

// File: rtl/gpio5_port.sv
// Module: gpio5_port (top)
// Five-pin I/O port: output latch, direction register, synchronized read
// path with analog masking, open-drain top pin and a timer clock tap.
// Assumes: pins above NANA-1 have no analog function; the open-drain pin
// is the highest one.
module gpio5_port
    import gpio5_pkg::*;
#(
    parameter int NPIN   = 5,
    parameter int NANA   = 4,
    parameter int DW     = 8,
    parameter int STAGES = 2,
    localparam int BW    = $clog2(DW),
    localparam int OD    = NPIN - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [1:0]      wr_op,
    input  logic [BW-1:0]   wr_bit,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      ana_cfg,
    input  logic [NPIN-1:0] pin_in,
    output logic [DW-1:0]   port_rd,
    output logic [DW-1:0]   dir_rd,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_out,
    output logic            tmr_clk
);

    logic [NPIN-1:0] pin_sync;
    logic [NANA-1:0] ana_mask;
    logic [NPIN-1:0] mask_full;
    logic [NPIN-1:0] pin_view;
    logic [NPIN-1:0] lat_q;
    logic [NPIN-1:0] dir_q;

    gpio5_sync #(.W(NPIN), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio5_ana_map #(.NANA(NANA)) u_ana (
        .ana_cfg  (ana_cfg),
        .ana_mask (ana_mask)
    );

    // Extend the analog mask over pins that cannot be analog
    always_comb begin
        mask_full = '0;
        mask_full[NANA-1:0] = ana_mask;
    end

    assign pin_view = pin_sync & ~mask_full;

    gpio5_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_op    (wr_op),
        .wr_bit   (wr_bit),
        .wr_data  (wr_data),
        .pin_view (pin_view),
        .lat_q    (lat_q),
        .dir_q    (dir_q)
    );

    gpio5_drv #(.NPIN(NPIN), .OD_IDX(OD)) u_drv (
        .lat_q   (lat_q),
        .dir_q   (dir_q),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    // Zero-extend the read values; unimplemented bits read 0
    always_comb begin
        port_rd = '0;
        dir_rd  = '0;
        port_rd[NPIN-1:0] = pin_view;
        dir_rd[NPIN-1:0]  = dir_q;
    end

    assign tmr_clk = pin_sync[OD];

    // R7
    all_analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_cfg == 2'b00) |-> (port_rd[NANA-1:0] == '0));

    // R7
    low_pair_analog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_cfg != 2'b11) |-> (port_rd[1:0] == 2'b00));

    // R5
    od_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[OD] |-> (!lat_q[OD] && !dir_rd[OD] && !pin_out[OD]));

endmodule

// File: tb/sim_gpio5_port.sv
module sim_gpio5_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       wr_sel;
    logic [1:0] wr_op;
    logic [2:0] wr_bit;
    logic [7:0] wr_data;
    logic [1:0] ana_cfg;
    logic [4:0] pin_in;
    logic [7:0] port_rd;
    logic [7:0] dir_rd;
    logic [4:0] pin_oe;
    logic [4:0] pin_out;
    logic       tmr_clk;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio5_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_op(wr_op), .wr_bit(wr_bit), .wr_data(wr_data),
        .ana_cfg(ana_cfg), .pin_in(pin_in), .port_rd(port_rd),
        .dir_rd(dir_rd), .pin_oe(pin_oe), .pin_out(pin_out),
        .tmr_clk(tmr_clk)
    );

    // Fields: cfg[47:46] pins[45:41] we[40] sel[39] op[38:37] bit[36:34]
    // data[33:26] exp_port[25:18] exp_dir[17:10] exp_oe[9:5] exp_out[4:0]
    localparam int NV = 16;
    localparam logic [47:0] TBL [NV] = '{
        // R3 R9: digital read, no write
        {2'b11, 5'b10101, 1'b0, 1'b0, 2'd0, 3'd0, 8'h00, 8'h15, 8'h00 | 8'h1F, 5'b00000, 5'b00000},
        // R4 R9: direction byte write, upper bits dropped
        {2'b11, 5'b10101, 1'b1, 1'b1, 2'd0, 3'd0, 8'hE0, 8'h15, 8'h00, 5'b11111, 5'b00000},
        // R2 R3 R5: latch all ones, read shows pins not latch
        {2'b11, 5'b01010, 1'b1, 1'b0, 2'd0, 3'd0, 8'hFF, 8'h0A, 8'h00, 5'b01111, 5'b01111},
        // R10: clear bit 2 copies zero pins over the ones in the latch
        {2'b11, 5'b00000, 1'b1, 1'b0, 2'd2, 3'd2, 8'h00, 8'h00, 8'h00, 5'b11111, 5'b00000},
        // R10 R5: set bit 1 copies pins 11001
        {2'b11, 5'b11001, 1'b1, 1'b0, 2'd1, 3'd1, 8'h00, 8'h19, 8'h00, 5'b01111, 5'b01011},
        // R7: code 00 masks pins 3..0
        {2'b00, 5'b11111, 1'b0, 1'b0, 2'd0, 3'd0, 8'h00, 8'h10, 8'h00, 5'b01111, 5'b01011},
        // R7: code 01 masks pins 1..0
        {2'b01, 5'b11111, 1'b0, 1'b0, 2'd0, 3'd0, 8'h00, 8'h1C, 8'h00, 5'b01111, 5'b01011},
        // R7: code 10 masks pins 1..0
        {2'b10, 5'b10110, 1'b0, 1'b0, 2'd0, 3'd0, 8'h00, 8'h14, 8'h00, 5'b01111, 5'b01011},
        // R10 R7: set bit 0 in analog mode copies zeros into pins 3..1
        {2'b00, 5'b11111, 1'b1, 1'b0, 2'd1, 3'd0, 8'h00, 8'h10, 8'h00, 5'b01111, 5'b00001},
        // R10 R2: set direction bit 3 works on the register itself
        {2'b11, 5'b00110, 1'b1, 1'b1, 2'd1, 3'd3, 8'h00, 8'h06, 8'h08, 5'b00111, 5'b00001},
        // R11: op 3 with data 0 changes nothing
        {2'b11, 5'b00110, 1'b1, 1'b0, 2'd3, 3'd0, 8'h00, 8'h06, 8'h08, 5'b00111, 5'b00001},
        // R10: clear direction bit 3
        {2'b11, 5'b00110, 1'b1, 1'b1, 2'd2, 3'd3, 8'h00, 8'h06, 8'h00, 5'b01111, 5'b00001},
        // R9 R2: direction byte 0xFF reads 0x1F, drivers off
        {2'b11, 5'b00110, 1'b1, 1'b1, 2'd0, 3'd0, 8'hFF, 8'h06, 8'h1F, 5'b00000, 5'b00001},
        // R4 R7: port byte write in analog mode
        {2'b00, 5'b11111, 1'b1, 1'b0, 2'd0, 3'd0, 8'h0E, 8'h10, 8'h1F, 5'b00000, 5'b01110},
        // R8: drivers enabled while pins are analog
        {2'b00, 5'b11111, 1'b1, 1'b1, 2'd0, 3'd0, 8'h00, 8'h10, 8'h00, 5'b11111, 5'b01110},
        // R10: index 6 changes no bit but copies pins 10011
        {2'b11, 5'b10011, 1'b1, 1'b0, 2'd1, 3'd6, 8'h00, 8'h13, 8'h00, 5'b01111, 5'b00011}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_sel = 1'b0; wr_op = 2'd0; wr_bit = 3'd0; wr_data = 8'h00;
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; idle(); ana_cfg = 2'b00; pin_in = 5'b11111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dir_rd", 32'(dir_rd), 32'h1F);
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        repeat (3) @(negedge clk);
        // R7 reset-time analog read with code 00
        chk("R7 port_rd analog", 32'(port_rd), 32'h10);

        for (int k = 0; k < NV; k++) begin
            logic [47:0] v;
            v = TBL[k];
            ana_cfg = v[47:46];
            pin_in  = v[45:41];
            idle();
            repeat (3) @(negedge clk);
            wr_en = v[40]; wr_sel = v[39]; wr_op = v[38:37];
            wr_bit = v[36:34]; wr_data = v[33:26];
            @(negedge clk);
            idle();
            chk($sformatf("vec%0d port_rd (R3 R7 R9)", k), 32'(port_rd), 32'(v[25:18]));
            chk($sformatf("vec%0d dir_rd (R4 R9 R10)", k), 32'(dir_rd), 32'(v[17:10]));
            chk($sformatf("vec%0d pin_oe (R2 R5 R8)", k), 32'(pin_oe), 32'(v[9:5]));
            chk($sformatf("vec%0d pin_out (R2 R5 R10 R11)", k), 32'(pin_out), 32'(v[4:0]));
        end

        // R6 R3: two-edge latency on pin 4 and pin 0 (pins were 10011)
        ana_cfg = 2'b11;
        pin_in = 5'b00010;
        @(negedge clk);
        chk("R6 tmr_clk after one edge", 32'(tmr_clk), 32'h1);
        chk("R3 port_rd after one edge", 32'(port_rd), 32'h13);
        @(negedge clk);
        chk("R6 tmr_clk after two edges", 32'(tmr_clk), 32'h0);
        chk("R3 port_rd after two edges", 32'(port_rd), 32'h02);
        pin_in = 5'b10000;
        repeat (2) @(negedge clk);
        chk("R6 tmr_clk rise", 32'(tmr_clk), 32'h1);

        // R5: latch 1 on pin 4 floats, latch 0 pulls low (direction 0 from last vector)
        wr_en = 1'b1; wr_sel = 1'b0; wr_op = 2'd0; wr_data = 8'h10;
        @(negedge clk);
        idle();
        chk("R5 pin4 floats for latch 1", 32'(pin_oe[4]), 32'h0);
        wr_en = 1'b1; wr_sel = 1'b0; wr_op = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        idle();
        chk("R5 pin4 pulls low for latch 0", 32'(pin_oe[4]), 32'h1);
        chk("R5 pin4 value", 32'(pin_out[4]), 32'h0);

        // R1: reset in mid-run restores the reset state
        wr_en = 1'b1; wr_sel = 1'b0; wr_op = 2'd0; wr_data = 8'h0F;
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mid-run dir_rd", 32'(dir_rd), 32'h1F);
        chk("R1 mid-run pin_out", 32'(pin_out), 32'h0);
        chk("R1 mid-run pin_oe", 32'(pin_oe), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule